// File: doc/BRIEF.md
# Interleaved Switching Phase Generator

This block sets the switching-period timing for one phase of a regulator in a group of modules that share one synchronisation line. A fast reference clock is divided down to the nominal switching period. Two straps and a five-bit lag code select the role. A module with both straps low is the timing master: it free-runs the period and pulses the shared line once per period. Any other setting makes the module a follower. A follower measures the spacing of rising edges on the line, checks that the spacing is inside the accepted frequency window, and places its own period-start strobe a programmable fraction of a period after each accepted edge.

The lag is the five-bit code times one thirty-second of the measured period, which is 11.25 degrees per step. When the lag-enable strap is low the code is ignored and the lag is zero. A follower that loses the line, or sees edges outside the window, raises a loss flag and stops strobing until two edges in a row arrive at a legal spacing. Only the rising edge of the line carries timing. The width of a line pulse, whether short or long, is never decoded. Every pin is a plain level with no handshake and no back-pressure. The straps are expected to be stable, and they change only while reset is held.

With the defaults (a 100-cycle nominal period and a ±5 % window), an accepted interval is 95 to 105 cycles, the loss timeout is 150 cycles, and the master pulse is 25 cycles wide.

Top module: `ilv_phase_gen`

## Requirements
- R1: While `rst_ni` is low, `period_stb_o` and `sync_drive_o` are 0, and `sync_lost_o` is 1 in follower mode and 0 in master mode.
- R2: Master mode is selected when `lag_en_strap_i`=0 and `lag_code_i`=5'b00000. In this mode `period_stb_o` pulses for one cycle every FAST_PER cycles, starting in the first cycle after reset is released, and `sync_lost_o` stays 0.
- R3: In master mode `sync_drive_o` is 1 for the first FAST_PER*PULSE_PCT/100 cycles of each period, beginning with the strobe cycle. In follower mode it is always 0.
- R4: In follower mode, with locked timing, suppose `sync_in_i` is first sampled high at clock edge k, and D is the number of cycles since the previous rising edge. Then `period_stb_o` is high for exactly one cycle, the one after edge k+2+floor(code*D/32). Here code is `lag_code_i` read as an unsigned number.
- R5: When `lag_en_strap_i`=0 and `lag_code_i` is not zero, the module is a follower with zero lag. The strobe follows each accepted edge by 2 cycles, whatever the code.
- R6: If no rising edge is seen for FAST_PER*3/2 cycles, the follower raises `sync_lost_o` and produces no strobe until it locks again.
- R7: A rising edge whose interval D lies outside [FAST_PER*(100-TOL_PCT)/100, FAST_PER*(100+TOL_PCT)/100] drops the lock. The next edge at a legal interval restores it. The first edge after reset or after a timeout never locks.
- R8: The high width of line pulses has no effect. Long pulses (75 % of a period) time the strobe exactly as short ones (25 %) do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lag_en_strap_i | input | 1 | 1 = lag from code, 0 = zero lag (master if code is also 0) |
| lag_code_i | input | 5 | Lag code, 11.25 degrees per count |
| sync_in_i | input | 1 | Shared synchronisation line as received |
| sync_drive_o | output | 1 | Master pulse onto the synchronisation line |
| period_stb_o | output | 1 | One-cycle phase-shifted period-start strobe |
| sync_lost_o | output | 1 | Follower has no valid timing |

## Verification
A corrupted interval counter or stored lag shows up at once as a strobe in the wrong cycle. The reference model predicts the exact cycle of every strobe, so the error is seen within one period of the corruption. A stuck lock flag shows up within one timeout, or within two edges: the loss flag and the strobe then disagree with the predicted window decisions. Errors in the master counter shift the strobe and the line pulse, which appear within one period. The window boundaries are exercised one cycle inside and one cycle outside each limit.

// File: rtl/ilv_phase_pkg.sv
package ilv_phase_pkg;
  localparam int unsigned LAG_BITS  = 5;
  localparam int unsigned LAG_STEPS = 1 << LAG_BITS;

  typedef enum logic [1:0] {
    MODE_MASTER     = 2'd0,
    MODE_FOLLOW_LAG = 2'd1,
    MODE_FOLLOW_0   = 2'd2
  } ilv_mode_e;
endpackage

// File: rtl/ilv_sync_edge.sv
module ilv_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o
);
  logic [STAGES:0] shreg;

  // synchroniser stages plus one history flop for edge detection
  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) shreg[0] <= 1'b0;
        else         shreg[0] <= line_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) shreg[g] <= 1'b0;
        else         shreg[g] <= shreg[g-1];
      end
    end
  end

  assign rise_o = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/ilv_master_tmr.sv
module ilv_master_tmr #(
  parameter int unsigned PER = 100,
  parameter int unsigned PW  = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic strobe_o,
  output logic drive_o
);
  localparam int unsigned MW = (PER > 1) ? $clog2(PER) : 1;
  localparam logic [MW-1:0] LAST  = MW'(PER - 1);
  localparam logic [MW-1:0] WIDTH = MW'(PW);

  logic [MW-1:0] cnt_q;

  // parked at the last count so the first enabled cycle starts a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= LAST;
    else if (!en_i)         cnt_q <= LAST;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign strobe_o = en_i && (cnt_q == '0);
  assign drive_o  = en_i && (cnt_q < WIDTH);
endmodule

// File: rtl/ilv_follow_trk.sv
module ilv_follow_trk #(
  parameter int unsigned PMIN = 95,
  parameter int unsigned PMAX = 105,
  parameter int unsigned TMO  = 150,
  parameter int unsigned CW   = 8,
  parameter int unsigned LAGW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            rise_i,
  input  logic [LAGW-1:0] code_i,
  output logic            strobe_o,
  output logic            lost_o
);
  localparam logic [CW-1:0] SAT = CW'(TMO - 1);
  localparam logic [CW-1:0] LO  = CW'(PMIN);
  localparam logic [CW-1:0] HI  = CW'(PMAX);

  logic [CW-1:0]      ival_q;
  logic [CW-1:0]      off_q;
  logic               lock_q;
  logic [CW-1:0]      meas;
  logic               in_win;
  logic [LAGW+CW-1:0] prod;

  assign meas   = ival_q + 1'b1;
  assign in_win = (meas >= LO) && (meas <= HI);
  assign prod   = {{CW{1'b0}}, code_i} * {{LAGW{1'b0}}, meas};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ival_q <= SAT;
      off_q  <= '0;
      lock_q <= 1'b0;
    end else if (!en_i) begin
      ival_q <= SAT;
      off_q  <= '0;
      lock_q <= 1'b0;
    end else if (rise_i) begin
      ival_q <= '0;
      lock_q <= in_win;
      if (in_win) off_q <= prod[LAGW+CW-1:LAGW];
    end else if (ival_q == SAT) begin
      lock_q <= 1'b0;
    end else begin
      ival_q <= ival_q + 1'b1;
    end
  end

  assign strobe_o = en_i && lock_q && (ival_q == off_q);
  assign lost_o   = en_i && !lock_q;
endmodule

// File: rtl/ilv_phase_gen.sv
module ilv_phase_gen
  import ilv_phase_pkg::*;
#(
  parameter int unsigned FAST_PER    = 100,
  parameter int unsigned TOL_PCT     = 5,
  parameter int unsigned PULSE_PCT   = 25,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lag_en_strap_i,
  input  logic [LAG_BITS-1:0] lag_code_i,
  input  logic                sync_in_i,
  output logic                sync_drive_o,
  output logic                period_stb_o,
  output logic                sync_lost_o
);
  localparam int unsigned PMIN = FAST_PER * (100 - TOL_PCT) / 100;
  localparam int unsigned PMAX = FAST_PER * (100 + TOL_PCT) / 100;
  localparam int unsigned TMO  = FAST_PER * 3 / 2;
  localparam int unsigned PW   = FAST_PER * PULSE_PCT / 100;
  localparam int unsigned CW   = $clog2(TMO + 1);

  ilv_mode_e           mode;
  logic                is_master;
  logic [LAG_BITS-1:0] eff_code;
  logic                line_rise;
  logic                m_stb, m_drv, f_stb, f_lost;

  always_comb begin
    if (!lag_en_strap_i && (lag_code_i == '0)) mode = MODE_MASTER;
    else if (!lag_en_strap_i)                  mode = MODE_FOLLOW_0;
    else                                       mode = MODE_FOLLOW_LAG;
  end

  assign is_master = (mode == MODE_MASTER);
  assign eff_code  = (mode == MODE_FOLLOW_LAG) ? lag_code_i : '0;

  ilv_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (sync_in_i),
    .rise_o (line_rise)
  );

  ilv_master_tmr #(.PER(FAST_PER), .PW(PW)) u_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (is_master),
    .strobe_o (m_stb),
    .drive_o  (m_drv)
  );

  ilv_follow_trk #(
    .PMIN(PMIN), .PMAX(PMAX), .TMO(TMO), .CW(CW), .LAGW(LAG_BITS)
  ) u_follow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (!is_master),
    .rise_i   (line_rise),
    .code_i   (eff_code),
    .strobe_o (f_stb),
    .lost_o   (f_lost)
  );

  assign period_stb_o = is_master ? m_stb : f_stb;
  assign sync_drive_o = m_drv;
  assign sync_lost_o  = f_lost;
endmodule

// File: rtl/ilv_phase_chk.sv
module ilv_phase_chk #(
  parameter int unsigned FAST_PER  = 100,
  parameter int unsigned PULSE_PCT = 25
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lag_en_strap_i,
  input logic [4:0] lag_code_i,
  input logic       sync_drive_o,
  input logic       period_stb_o,
  input logic       sync_lost_o
);
  localparam int unsigned PW = FAST_PER * PULSE_PCT / 100;

  logic        is_master;
  int unsigned gap;
  int unsigned run;
  logic        seen;

  assign is_master = !lag_en_strap_i && (lag_code_i == 5'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap  <= 0;
      run  <= 0;
      seen <= 1'b0;
    end else begin
      if (period_stb_o) begin
        gap  <= 0;
        seen <= 1'b1;
      end else if (gap < 32'hFFFF) begin
        gap <= gap + 1;
      end
      if (sync_drive_o) run <= run + 1;
      else              run <= 0;
    end
  end

  a_r2_master_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master && period_stb_o && seen) |-> (gap == FAST_PER - 1))
    else $error("R2 master strobe spacing");

  a_r2_master_never_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_master |-> !sync_lost_o)
    else $error("R2 master reports loss");

  a_r3_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_drive_o |-> (run < PW))
    else $error("R3 line pulse too long");

  a_r3_pulse_starts_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_drive_o) |-> period_stb_o)
    else $error("R3 pulse not aligned with strobe");

  a_r3_follower_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_master |-> !sync_drive_o)
    else $error("R3 follower drives line");

  a_r6_no_strobe_when_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_lost_o |-> !period_stb_o)
    else $error("R6 strobe while lost");
endmodule

bind ilv_phase_gen ilv_phase_chk #(
  .FAST_PER  (FAST_PER),
  .PULSE_PCT (PULSE_PCT)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lag_en_strap_i (lag_en_strap_i),
  .lag_code_i     (lag_code_i),
  .sync_drive_o   (sync_drive_o),
  .period_stb_o   (period_stb_o),
  .sync_lost_o    (sync_lost_o)
);

// File: tb/ilv_phase_gen_tb.sv
module ilv_phase_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 100;
  localparam int PMIN = 95;
  localparam int PMAX = 105;
  localparam int TMO  = 150;
  localparam int PW   = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lag_en = 1'b1;
  logic [4:0] code = 5'd0;
  logic       sync_in = 1'b0;
  logic       drv, stb, lost;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  ilv_phase_gen dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .lag_en_strap_i (lag_en),
    .lag_code_i     (code),
    .sync_in_i      (sync_in),
    .sync_drive_o   (drv),
    .period_stb_o   (stb),
    .sync_lost_o    (lost)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  int  cyc = 0;
  int  m_cnt = P - 1;
  int  m_ival = TMO - 1;
  int  m_off = 0;
  bit  m_lock = 0;
  bit  hist[$] = '{0, 0, 0};
  bit  prev_in = 0;
  int  rise_cyc = 0;
  int  stb_delay = -1;
  int  stb_cnt = 0;
  int  drv_cnt = 0;

  function automatic bit master_mode();
    return (lag_en == 1'b0) && (code == 5'd0);
  endfunction

  always @(posedge clk) begin
    bit rise;
    int meas;
    int ecode;
    cyc++;
    if (sync_in && !prev_in) rise_cyc = cyc;
    prev_in = sync_in;
    if (!rst_n) begin
      m_cnt = P - 1; m_ival = TMO - 1; m_off = 0; m_lock = 0;
      hist = '{0, 0, 0};
    end else begin
      rise = hist[1] && !hist[2];
      hist.push_front(sync_in);
      void'(hist.pop_back());
      if (master_mode()) begin
        m_cnt = (m_cnt + 1) % P;
      end else begin
        ecode = lag_en ? int'(code) : 0;
        if (rise) begin
          meas = m_ival + 1;
          if (meas >= PMIN && meas <= PMAX) begin
            m_lock = 1;
            m_off = ecode * meas / 32;
          end else m_lock = 0;
          m_ival = 0;
        end else if (m_ival == TMO - 1) m_lock = 0;
        else m_ival++;
      end
    end
    #2;
    begin
      int e_stb, e_drv, e_lost;
      if (master_mode()) begin
        e_stb = (rst_n && m_cnt == 0) ? 1 : 0;
        e_drv = (rst_n && m_cnt < PW) ? 1 : 0;
        e_lost = 0;
      end else begin
        e_stb = (m_lock && m_ival == m_off) ? 1 : 0;
        e_drv = 0;
        e_lost = m_lock ? 0 : 1;
      end
      chk("R4", "strobe vs model", int'(stb), e_stb);
      chk("R3", "line drive vs model", int'(drv), e_drv);
      chk("R6", "loss flag vs model", int'(lost), e_lost);
      if (stb) begin
        stb_cnt++;
        stb_delay = cyc - rise_cyc;
      end
      if (drv) drv_cnt++;
    end
  end

  task automatic do_reset(input logic en, input logic [4:0] c);
    @(negedge clk);
    rst_n = 1'b0; sync_in = 1'b0; lag_en = en; code = c;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    stb_cnt = 0; drv_cnt = 0;
  endtask

  task automatic pulses(input int per, input int hi, input int n);
    for (int j = 0; j < n; j++)
      for (int i = 0; i < per; i++) begin
        @(negedge clk);
        sync_in = (i < hi);
      end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync_in = 1'b0;
    end
  endtask

  task automatic lag_case(input logic [4:0] c, input int exp_delay, input string tag);
    do_reset(1'b1, c);
    release_reset();
    pulses(P, 25, 3);
    stb_cnt = 0;
    pulses(P, 25, 2);
    chk(tag, "strobe delay", stb_delay, exp_delay);
    chk(tag, "strobes per two periods", stb_cnt, 2);
  endtask

  initial begin
    // R1 follower reset state
    do_reset(1'b1, 5'd8);
    chk("R1", "reset lost", int'(lost), 1);
    chk("R1", "reset strobe", int'(stb), 0);
    chk("R1", "reset drive", int'(drv), 0);
    release_reset();
    pulses(P, 25, 4);
    chk("R4", "code 8 delay", stb_delay, 2 + 8 * P / 32);
    chk("R7", "locked after legal edges", int'(lost), 0);
    chk("R3", "follower never drives", drv_cnt, 0);
    // R8 long pulses
    pulses(P, 75, 3);
    chk("R8", "long pulse delay", stb_delay, 2 + 8 * P / 32);
    chk("R8", "still locked", int'(lost), 0);
    // R6 timeout
    idle(200);
    chk("R6", "lost after silence", int'(lost), 1);
    stb_cnt = 0;
    idle(100);
    chk("R6", "no strobe while lost", stb_cnt, 0);
    // R4 other codes
    lag_case(5'd31, 2 + 31 * P / 32, "R4");
    lag_case(5'd1, 2 + P / 32, "R4");
    // R5 zero-lag strap
    do_reset(1'b0, 5'd21);
    release_reset();
    pulses(P, 25, 4);
    chk("R5", "strap forces zero lag", stb_delay, 2);
    chk("R5", "follower not master", int'(lost), 0);
    // R7 window edges
    do_reset(1'b1, 5'd0);
    release_reset();
    pulses(P, 25, 3);
    pulses(PMAX, 25, 2);
    chk("R7", "upper limit accepted", int'(lost), 0);
    pulses(PMIN, 25, 2);
    chk("R7", "lower limit accepted", int'(lost), 0);
    pulses(PMAX + 1, 25, 2);
    chk("R7", "above window rejected", int'(lost), 1);
    pulses(P, 25, 2);
    chk("R7", "relock after legal edge", int'(lost), 0);
    pulses(PMIN - 1, 25, 2);
    chk("R7", "below window rejected", int'(lost), 1);
    // R1/R2/R3 master
    do_reset(1'b0, 5'd0);
    chk("R1", "master reset lost", int'(lost), 0);
    chk("R1", "master reset strobe", int'(stb), 0);
    chk("R1", "master reset drive", int'(drv), 0);
    release_reset();
    repeat (10 * P) @(negedge clk);
    chk("R2", "master strobes in ten periods", stb_cnt, 10);
    chk("R3", "master drive cycles", drv_cnt, 10 * PW);
    chk("R2", "master not lost", int'(lost), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule